// File: doc/BRIEF.md
# UART Transmit Path with Holding-Empty Interrupt

This block is the transmit half of a 16550-style serial port register model. A host writes bytes over a small register bus. They go either into a single holding register or, with queueing enabled, into a 16-entry transmit queue. A shift engine then sends them on a serial line, one start bit, eight data bits least significant first and one stop bit. Each bit lasts the divisor value times 16 clocks.

The block keeps two line status flags: "holding empty" (THRE) and "transmitter empty" (TEMT). It also keeps a holding-empty pending flag that drives the interrupt output through an interrupt enable register. The pending flag is re-armed only on a rising edge of its enable bit. A transmit queue reset forces holding empty and raises the pending flag. A receive reset clears the receive status bits, which a neighbouring receive path sets through three pulse inputs.

The shift engine is a state machine with four states:
- IDLE goes to START when a byte is loaded.
- START goes to DATA at the end of the start bit.
- DATA stays in DATA for each of the first seven bits and goes to STOP after the eighth.
- STOP goes back to IDLE at the end of the stop bit, raising a one-cycle done pulse.

A new byte is loaded from IDLE whenever holding empty is 0.

Top module: `uart_thre_tx`

Register map (bus_addr):
- 0: write the holding register.
- 1: interrupt enable, read and write.
  - bit0: receive data and timeout
  - bit1: holding empty
  - bit2: line status
- 2: on write, FIFO control.
  - bit0: queue enable
  - bit1: receive reset
  - bit2: transmit reset
- 2: on read, interrupt identification. Bits [7:6] are 11 when queueing is enabled. Bits [3:0] hold the code:
  - 0x1: none
  - 0x6: line status
  - 0x4: data ready
  - 0xC: timeout
  - 0x2: holding empty
- 3: line status, read only.
  - bit0: data ready
  - bit4: break
  - bit5: THRE
  - bit6: TEMT
- 4: divisor, read and write.

## Requirements
- R1: After reset, line status reads 0x60, interrupt enable reads 0x00, identification reads 0x01, tx_line is 1 and irq is 0.
- R2: A frame is a 0 start bit, 8 data bits LSB first and a 1 stop bit, each lasting divisor×16 clocks (a divisor of 0 acts as 1).
- R3: A write to address 0 clears THRE, TEMT and the pending flag in the next cycle, so line status reads 0x00 and irq is 0.
- R4: With queueing off, THRE sets and the pending flag rises one cycle after the holding write, when the byte enters the shifter. TEMT stays 0 until the stop bit ends, after which status reads 0x60.
- R5: With queueing on, THRE stays 0 until the last queued byte enters the shifter. Bytes leave in write order, and TEMT sets only after the final stop bit.
- R6: A holding write to a full 16-entry queue discards the oldest queued byte and queues the new one.
- R7: The interrupt enable register keeps only its low 4 bits; writing 0xFF reads back 0x0F.
- R8: When enable bit1 rises while THRE is 1, the pending flag is set. When bit1 falls, or rises with THRE at 0, the flag is cleared. A write that leaves bit1 unchanged keeps it.
- R9: irq is 1 exactly when an enabled source is pending: break with bit2, data ready or timeout with bit0, holding empty with bit1.
- R10: Reading identification while it reports 0x2 clears the pending flag.
- R11: A FIFO control write with bit2 set, or one that changes bit0, empties transmit storage, sets THRE and sets the pending flag. Queued bytes not yet in the shifter are never sent.
- R12: A FIFO control write with bit1 set clears data ready, break and timeout pending, and leaves the transmit side unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_re | input | 1 | Read strobe (side effects on identification read) |
| bus_rdata | output | 8 | Read data, combinational from address |
| rx_dr_set | input | 1 | Receive path pulse: data ready |
| rx_bi_set | input | 1 | Receive path pulse: break seen |
| rx_tmo_set | input | 1 | Receive path pulse: character timeout |
| tx_line | output | 1 | Serial output, idles high |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a full queue overflowing while the shifter holds the first byte. The stimulus issues eighteen holding writes on consecutive cycles: the first byte is loaded one cycle after its write, and the seventeenth queued write falls on a full queue. The scoreboard expects every byte except the second. A second hard case is raising the holding-empty enable while THRE is 0. This is reached mid-frame with bytes still queued, so the enable edge arrives while holding empty is low. The divisor is also raised to 2 for one frame so that mid-bit sampling checks the bit length.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;

    typedef enum logic [1:0] {
        TXS_IDLE  = 2'd0,
        TXS_START = 2'd1,
        TXS_DATA  = 2'd2,
        TXS_STOP  = 2'd3
    } tx_state_e;

    localparam logic [2:0] ADDR_THR = 3'd0;
    localparam logic [2:0] ADDR_IER = 3'd1;
    localparam logic [2:0] ADDR_FCR = 3'd2;
    localparam logic [2:0] ADDR_LSR = 3'd3;
    localparam logic [2:0] ADDR_DIV = 3'd4;

    localparam int IER_RX   = 0;
    localparam int IER_THRE = 1;
    localparam int IER_LINE = 2;

    localparam int FCR_EN    = 0;
    localparam int FCR_RXCLR = 1;
    localparam int FCR_TXCLR = 2;

    localparam logic [3:0] IIR_NONE = 4'h1;
    localparam logic [3:0] IIR_LINE = 4'h6;
    localparam logic [3:0] IIR_RXD  = 4'h4;
    localparam logic [3:0] IIR_TMO  = 4'hC;
    localparam logic [3:0] IIR_THRE = 4'h2;

endpackage

// File: rtl/uart_txq.sv
`timescale 1ns/1ps
module uart_txq #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= nxt(wr_ptr);
            if (pop)  rd_ptr <= nxt(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign rdata = mem[rd_ptr];

endmodule

// File: rtl/uart_tx_ser.sv
`timescale 1ns/1ps
module uart_tx_ser
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 8,
    localparam int BW   = DIV_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             start,
    input  logic [7:0]       data,
    output logic             tx,
    output logic             busy,
    output logic             done
);

    tx_state_e      state_q;
    tx_state_e      state_d;
    logic [BW-1:0]  cyc_q;
    logic [2:0]     bitn_q;
    logic [7:0]     sr_q;
    logic [DIV_W-1:0] div_eff;
    logic [BW-1:0]  bit_last;
    logic           tick;

    assign div_eff  = (divisor == '0) ? DIV_W'(1) : divisor;
    assign bit_last = {div_eff, 4'b0000} - 1'b1;
    assign tick     = (state_q != TXS_IDLE) && (cyc_q == bit_last);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXS_IDLE:  if (start) state_d = TXS_START;
            TXS_START: if (tick)  state_d = TXS_DATA;
            TXS_DATA:  if (tick && bitn_q == 3'd7) state_d = TXS_STOP;
            TXS_STOP:  if (tick)  state_d = TXS_IDLE;
            default:   state_d = TXS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TXS_IDLE;
            cyc_q   <= '0;
            bitn_q  <= '0;
            sr_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TXS_IDLE) begin
                cyc_q  <= '0;
                bitn_q <= '0;
                if (start) sr_q <= data;
            end else if (tick) begin
                cyc_q <= '0;
                if (state_q == TXS_DATA) begin
                    sr_q   <= {1'b0, sr_q[7:1]};
                    bitn_q <= bitn_q + 1'b1;
                end
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            TXS_START: tx = 1'b0;
            TXS_DATA:  tx = sr_q[0];
            default:   tx = 1'b1;
        endcase
        busy = (state_q != TXS_IDLE);
        done = (state_q == TXS_STOP) && tick;
    end

endmodule

// File: rtl/uart_thre_tx.sv
`timescale 1ns/1ps
module uart_thre_tx
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_W      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    input  logic       bus_re,
    output logic [7:0] bus_rdata,
    input  logic       rx_dr_set,
    input  logic       rx_bi_set,
    input  logic       rx_tmo_set,
    output logic       tx_line,
    output logic       irq
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic             fifo_en, thre, temt, pend;
    logic [3:0]       ier;
    logic [7:0]       thr;
    logic [DIV_W-1:0] div_q;
    logic             dr, bi, tmo;
    logic [3:0]       iir_code;
    logic [3:0]       ier_chg;

    logic             wr_thr, wr_ier, wr_fcr, wr_div, rd_iir;
    logic             tx_clr, rx_clr, load, thre_set_evt, q_full;
    logic             q_push, q_pop;
    logic [7:0]       q_head, ld_byte;
    logic [CNT_W-1:0] txq_count;
    logic             ser_busy, ser_done;

    assign wr_thr  = bus_we && (bus_addr == ADDR_THR);
    assign wr_ier  = bus_we && (bus_addr == ADDR_IER);
    assign wr_fcr  = bus_we && (bus_addr == ADDR_FCR);
    assign wr_div  = bus_we && (bus_addr == ADDR_DIV);
    assign rd_iir  = bus_re && (bus_addr == ADDR_FCR);
    assign ier_chg = ier ^ bus_wdata[3:0];

    assign tx_clr  = wr_fcr && (bus_wdata[FCR_TXCLR] || (bus_wdata[FCR_EN] != fifo_en));
    assign rx_clr  = wr_fcr && bus_wdata[FCR_RXCLR];
    assign q_full  = (txq_count == CNT_W'(FIFO_DEPTH));
    assign load    = !thre && !ser_busy && !tx_clr;
    assign ld_byte = fifo_en ? q_head : thr;
    assign thre_set_evt = load && !wr_thr && (!fifo_en || (txq_count == CNT_W'(1)));
    assign q_push  = wr_thr && fifo_en;
    assign q_pop   = fifo_en && (load || (wr_thr && q_full));

    uart_txq #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_clr),
        .push  (q_push),
        .pop   (q_pop),
        .wdata (bus_wdata),
        .rdata (q_head),
        .count (txq_count)
    );

    uart_tx_ser #(.DIV_W(DIV_W)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (div_q),
        .start   (load),
        .data    (ld_byte),
        .tx      (tx_line),
        .busy    (ser_busy),
        .done    (ser_done)
    );

    always_comb begin
        if (ier[IER_LINE] && bi)               iir_code = IIR_LINE;
        else if (ier[IER_RX] && dr)            iir_code = IIR_RXD;
        else if (ier[IER_RX] && tmo)           iir_code = IIR_TMO;
        else if (ier[IER_THRE] && pend)        iir_code = IIR_THRE;
        else                                   iir_code = IIR_NONE;
    end

    assign irq = (ier[IER_LINE] && bi) || (ier[IER_RX] && (dr || tmo)) ||
                 (ier[IER_THRE] && pend);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_en <= 1'b0;
            thre    <= 1'b1;
            temt    <= 1'b1;
            pend    <= 1'b0;
            ier     <= '0;
            thr     <= '0;
            div_q   <= DIV_W'(1);
            dr      <= 1'b0;
            bi      <= 1'b0;
            tmo     <= 1'b0;
        end else begin
            if (wr_thr) thr <= bus_wdata;
            if (wr_ier) ier <= bus_wdata[3:0];
            if (wr_div) div_q <= DIV_W'(bus_wdata);
            if (wr_fcr) fifo_en <= bus_wdata[FCR_EN];

            if (tx_clr)            thre <= 1'b1;
            else if (wr_thr)       thre <= 1'b0;
            else if (thre_set_evt) thre <= 1'b1;

            if (wr_thr)                                temt <= 1'b0;
            else if (thre && (!ser_busy || ser_done))  temt <= 1'b1;

            if (tx_clr)                              pend <= 1'b1;
            else if (wr_thr)                         pend <= 1'b0;
            else if (thre_set_evt)                   pend <= 1'b1;
            else if (wr_ier && ier_chg[IER_THRE])    pend <= bus_wdata[IER_THRE] && thre;
            else if (rd_iir && iir_code == IIR_THRE) pend <= 1'b0;

            if (rx_clr) begin
                dr  <= 1'b0;
                bi  <= 1'b0;
                tmo <= 1'b0;
            end else begin
                dr  <= dr  || rx_dr_set;
                bi  <= bi  || rx_bi_set;
                tmo <= tmo || rx_tmo_set;
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_IER: bus_rdata = {4'b0000, ier};
            ADDR_FCR: bus_rdata = {fifo_en, fifo_en, 2'b00, iir_code};
            ADDR_LSR: bus_rdata = {1'b0, temt, thre, bi, 3'b000, dr};
            ADDR_DIV: bus_rdata = 8'(div_q);
            default:  bus_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/uart_thre_tx_chk.sv
`timescale 1ns/1ps
module uart_thre_tx_chk
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [2:0]       bus_addr,
    input logic             txclr_bit,
    input logic             thre,
    input logic             temt,
    input logic             pend,
    input logic             thre_en,
    input logic             irq,
    input logic             tx_line,
    input logic [CNT_W-1:0] txq_count
);

    a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_THR) |=> (!thre && !temt && !pend));

    a_r4_temt_needs_thre: assert property (@(posedge clk) disable iff (!rst_n)
        temt |-> thre);

    a_r4_line_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        temt |-> tx_line);

    a_r11_txreset_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_FCR && txclr_bit) |=> (thre && pend));

    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        txq_count <= CNT_W'(FIFO_DEPTH));

    a_r9_irq_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && thre_en) |-> irq);

endmodule

bind uart_thre_tx uart_thre_tx_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .txclr_bit (bus_wdata[2]),
    .thre      (thre),
    .temt      (temt),
    .pend      (pend),
    .thre_en   (ier[1]),
    .irq       (irq),
    .tx_line   (tx_line),
    .txq_count (txq_count)
);

// File: tb/uart_thre_tx_tb.sv
`timescale 1ns/1ps
module uart_thre_tx_tb;
    import uart_tx_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] bus_addr;
    logic       bus_we;
    logic [7:0] bus_wdata;
    logic       bus_re;
    logic [7:0] bus_rdata;
    logic       rx_dr_set, rx_bi_set, rx_tmo_set;
    logic       tx_line;
    logic       irq;

    int         checks = 0;
    int         failures = 0;
    bit         finished = 1'b0;
    int         bit_clks = 16;
    logic       rd_irq;
    logic [7:0] expq [$];

    always #2.5 clk = ~clk;

    uart_thre_tx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_re     (bus_re),
        .bus_rdata  (bus_rdata),
        .rx_dr_set  (rx_dr_set),
        .rx_bi_set  (rx_bi_set),
        .rx_tmo_set (rx_tmo_set),
        .tx_line    (tx_line),
        .irq        (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        rd_irq = irq;
        @(posedge clk);
        #1 bus_re = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic irq_chk(input string req, input logic exp);
        check(req, {7'b0, rd_irq}, {7'b0, exp});
    endtask

    task automatic send(input logic [7:0] d);
        expq.push_back(d);
        wr(ADDR_THR, d);
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(ADDR_LSR, v);
            if (v[6]) break;
        end
    endtask

    task automatic pulse_rx(input logic d, input logic b, input logic t);
        @(negedge clk);
        rx_dr_set = d; rx_bi_set = b; rx_tmo_set = t;
        @(posedge clk);
        #1 rx_dr_set = 1'b0; rx_bi_set = 1'b0; rx_tmo_set = 1'b0;
    endtask

    // Monitor: decodes frames mid-bit and compares against the scoreboard queue
    initial begin
        @(posedge rst_n);
        forever begin
            logic [7:0] b;
            @(negedge tx_line);
            repeat (bit_clks / 2) @(posedge clk);
            #1 check("R2 start bit", {7'b0, tx_line}, 8'h00);
            for (int i = 0; i < 8; i++) begin
                repeat (bit_clks) @(posedge clk);
                #1 b[i] = tx_line;
            end
            repeat (bit_clks) @(posedge clk);
            #1 check("R2 stop bit", {7'b0, tx_line}, 8'h01);
            if (expq.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R6/R11 unexpected frame actual=0x%02h expected=none", b);
            end else begin
                check("R2/R5 byte order", b, expq.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; bus_re = 1'b0;
        rx_dr_set = 1'b0; rx_bi_set = 1'b0; rx_tmo_set = 1'b0; rd_irq = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 line status", ADDR_LSR, 8'h60);
        irq_chk("R1 irq", 1'b0);
        rd_chk("R1 enable", ADDR_IER, 8'h00);
        rd_chk("R1 ident", ADDR_FCR, 8'h01);
        check("R1 tx idle", {7'b0, tx_line}, 8'h01);

        // R7 / R8 / R9 / R10 enable handling with THRE=1
        wr(ADDR_IER, 8'hFF);
        rd_chk("R7 enable low nibble", ADDR_IER, 8'h0F);
        irq_chk("R8 rising enable raises", 1'b1);
        rd_chk("R10 ident holding empty", ADDR_FCR, 8'h02);
        rd_chk("R10 ident cleared", ADDR_FCR, 8'h01);
        irq_chk("R9 irq low after clear", 1'b0);
        wr(ADDR_IER, 8'h0F);
        rd_chk("R8 same value no rearm", ADDR_FCR, 8'h01);
        irq_chk("R8 same value irq", 1'b0);
        wr(ADDR_IER, 8'h0D);
        wr(ADDR_IER, 8'h0F);
        rd_chk("R8 re-rise rearms", ADDR_FCR, 8'h02);
        irq_chk("R9 irq with pending", 1'b1);
        wr(ADDR_IER, 8'h02);

        // R3 / R4 non-queued transmit
        send(8'hA5);
        rd_chk("R3 status after write", ADDR_LSR, 8'h00);
        irq_chk("R3 irq after write", 1'b0);
        rd_chk("R4 THRE after load", ADDR_LSR, 8'h20);
        irq_chk("R4 irq after load", 1'b1);
        repeat (50) @(posedge clk);
        rd_chk("R4 TEMT low mid-frame", ADDR_LSR, 8'h20);
        wait_idle();
        rd_chk("R4 status after frame", ADDR_LSR, 8'h60);
        rd_chk("R10 ident after frame", ADDR_FCR, 8'h02);

        // R2 divisor 2
        wr(ADDR_DIV, 8'h02);
        bit_clks = 32;
        send(8'h3C);
        repeat (300) @(posedge clk);
        rd_chk("R2 frame length with divisor 2", ADDR_LSR, 8'h20);
        wait_idle();
        rd_chk("R10 ident div2", ADDR_FCR, 8'h02);
        wr(ADDR_DIV, 8'h01);
        bit_clks = 16;

        // R5 queued transmit, R11 enable change, R8 rising with THRE=0
        wr(ADDR_FCR, 8'h01);
        rd_chk("R11 enable change pends", ADDR_FCR, 8'hC2);
        send(8'h11);
        send(8'h22);
        send(8'h33);
        rd_chk("R5 status with queue", ADDR_LSR, 8'h00);
        wr(ADDR_IER, 8'h00);
        wr(ADDR_IER, 8'h02);
        rd_chk("R8 rise with THRE low", ADDR_FCR, 8'hC1);
        irq_chk("R8 irq stays low", 1'b0);
        repeat (200) @(posedge clk);
        rd_chk("R5 THRE low while queued", ADDR_LSR, 8'h00);
        for (int i = 0; i < 2000; i++) begin
            rd(ADDR_LSR, v);
            if (v[5]) break;
        end
        check("R5 THRE before TEMT", v, 8'h20);
        wait_idle();
        rd_chk("R5 status after queue", ADDR_LSR, 8'h60);
        rd_chk("R5 ident after queue", ADDR_FCR, 8'hC2);

        // R6 overflow: 18 back-to-back writes, byte 1 is dropped
        for (int i = 0; i < 18; i++) begin
            if (i != 1) expq.push_back(8'h40 + 8'(i));
            wr(ADDR_THR, 8'h40 + 8'(i));
        end
        wait_idle();
        rd_chk("R6 status after overflow", ADDR_LSR, 8'h60);
        rd_chk("R6 ident", ADDR_FCR, 8'hC2);

        // R11 transmit reset mid-frame
        send(8'h5A);
        wr(ADDR_THR, 8'hC3);
        wr(ADDR_THR, 8'h0F);
        wr(ADDR_THR, 8'hF0);
        wr(ADDR_FCR, 8'h05);
        rd_chk("R11 THRE forced, shifter busy", ADDR_LSR, 8'h20);
        irq_chk("R11 irq after reset", 1'b1);
        rd_chk("R11 ident", ADDR_FCR, 8'hC2);
        wait_idle();
        repeat (400) @(posedge clk);
        rd_chk("R11 idle after drop", ADDR_LSR, 8'h60);

        // R12 receive reset
        wr(ADDR_IER, 8'h05);
        pulse_rx(1'b1, 1'b1, 1'b0);
        rd_chk("R12 status before reset", ADDR_LSR, 8'h71);
        rd_chk("R9 line status priority", ADDR_FCR, 8'hC6);
        irq_chk("R9 irq break", 1'b1);
        wr(ADDR_FCR, 8'h03);
        rd_chk("R12 status after reset", ADDR_LSR, 8'h60);
        rd_chk("R12 ident after reset", ADDR_FCR, 8'hC1);
        irq_chk("R12 irq low", 1'b0);
        pulse_rx(1'b0, 1'b0, 1'b1);
        rd_chk("R9 timeout ident", ADDR_FCR, 8'hCC);
        irq_chk("R9 irq timeout", 1'b1);
        wr(ADDR_FCR, 8'h03);
        rd_chk("R12 timeout cleared", ADDR_FCR, 8'hC1);

        repeat (20) @(posedge clk);
        check("R11 scoreboard drained", 8'(expq.size()), 8'h00);
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule